// File: doc/BRIEF.md
# Token-Counting Coherence Controller for One Cache Line

This block is the per-cache controller for a single shared line under a token-counting coherence scheme. A line has a fixed number of tokens spread over all caches. The controller holds the local share of them. Read permission needs at least one token and write permission needs every token. No ordered state machine decides permission: the count alone decides it.

The local processor asks for a read or a write through a one-cycle operation strobe. If the count already allows the operation, the controller signals completion on the next cycle. If it does not, the controller records a pending operation and sends a request onto the request output. Requests from other caches arrive on the request input. The controller answers them with token responses addressed to the requester. Tokens that come back on the response input are added to the count.

A programmable timeout drives recovery from races. While the pending operation remains unsatisfied, the request is sent again each time the timeout runs out. The count changes only by tokens that are received or sent, so the controller neither creates nor loses any.

Top module: `tok_line_ctrl`

## Requirements
- R1: After synchronous reset the count equals INIT_TOKENS, nothing is pending, and the outputs `req_out_valid`, `rsp_out_valid` and `done` are low.
- R2: `rd_ok` is high exactly when the count is at least one. `wr_ok` is high exactly when the count equals TOTAL_TOKENS (default 16).
- R3: A foreign read request (`req_in_write`=0, source different from NODE_ID) that arrives while the count equals TOTAL_TOKENS produces, on the next cycle, a response of exactly one token to that source, and the count drops to TOTAL_TOKENS-1. A foreign read that arrives while the count is below the total gets no response and leaves the count as it was.
- R4: A foreign write request (`req_in_write`=1) that arrives while the count is non-zero produces, on the next cycle, a response that carries the whole count to that source, and the count becomes zero. This holds even when the count is one.
- R5: A request is ignored when the count is zero or when its source equals NODE_ID. Ignored means no response and no change to the count.
- R6: Tokens that arrive on the response input (`rsp_in_valid` with `rsp_in_tokens`) are added to the count at the same clock edge that subtracts any tokens being sent.
- R7: A local operation (`op_valid`, with `op_write` 1 for write and 0 for read) whose permission is not met sets `pend`. On the next cycle it raises `req_out_valid` for one cycle, with `req_out_write` equal to the operation kind and `req_out_src` equal to NODE_ID.
- R8: A local operation whose permission is already met pulses `done` on the next cycle. It issues no request and does not set `pend`.
- R9: While a pending operation is unsatisfied, the request is sent again exactly `timeout_limit` cycles after the previous issue. A limit of 0 behaves like a limit of 1.
- R10: When the count meets the permission of the pending operation, `pend` clears on the next edge and `done` pulses for one cycle. A pending write completes only once the count has reached TOTAL_TOKENS.
- R11: Tokens are conserved. Each cycle the new count equals the previous count, plus the tokens received, minus the tokens carried by the response that was just emitted.
- R12: A local operation strobed while `pend` is high is ignored. It produces no `done`, no extra request, and no change of kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Local operation strobe |
| op_write | input | 1 | Local operation kind: 1 write, 0 read |
| timeout_limit | input | TW | Cycles between request issues |
| req_in_valid | input | 1 | Incoming request valid |
| req_in_write | input | 1 | Incoming request kind: 1 write, 0 read |
| req_in_src | input | IDW | Node number of the requester |
| rsp_in_valid | input | 1 | Incoming token response valid |
| rsp_in_tokens | input | CW | Tokens carried by the incoming response |
| req_out_valid | output | 1 | Outgoing request pulse |
| req_out_write | output | 1 | Outgoing request kind |
| req_out_src | output | IDW | This node's number |
| rsp_out_valid | output | 1 | Outgoing token response valid |
| rsp_out_dst | output | IDW | Node the response is addressed to |
| rsp_out_tokens | output | CW | Tokens carried by the outgoing response |
| tokens | output | CW | Current local token count |
| rd_ok | output | 1 | Read permission |
| wr_ok | output | 1 | Write permission |
| pend | output | 1 | A local operation is waiting |
| done | output | 1 | One-cycle completion pulse |

## Verification
Directed sequences take the line through the cases that separate the answer rules. A read that reaches a full holder and a read that reaches a partial holder must give different results. A write that strips sixteen tokens and a write that strips a single leftover token must both empty the count, and requests that meet an empty count or carry this node's own number must have no effect. Further sequences time the reissue at limits of 3 and 0 and test an operation strobe sent during a pending operation. Random mixes of foreign requests, token returns and local operations, under several timeout limits, then compare every output with a cycle model and with a balance of the tokens held outside the block. Under these mixes, completions that come from tokens arriving while a request is pending are told apart from completions that were met from the start.

// File: rtl/tok_pkg.sv
`timescale 1ns/1ps
package tok_pkg;

    localparam int unsigned DEF_TOTAL = 16;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } op_kind_e;

    // Permission test: a read needs one token, a write needs all of them.
    function automatic logic perm_met(input int unsigned cnt,
                                      input int unsigned total,
                                      input op_kind_e    kind);
        if (kind == OP_WRITE) return cnt == total;
        return cnt != 0;
    endfunction

    function automatic int unsigned id_width(input int unsigned nodes);
        return (nodes > 1) ? $clog2(nodes) : 1;
    endfunction

endpackage

// File: rtl/tok_count.sv
`timescale 1ns/1ps
module tok_count
    import tok_pkg::*;
#(
    parameter int unsigned TOTAL_TOKENS = DEF_TOTAL,
    parameter int unsigned INIT_TOKENS  = 0,
    parameter int unsigned NODE_ID      = 0,
    parameter int unsigned IDW          = 2,
    parameter int unsigned CW           = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           req_in_valid,
    input  logic           req_in_write,
    input  logic [IDW-1:0] req_in_src,
    input  logic           rsp_in_valid,
    input  logic [CW-1:0]  rsp_in_tokens,
    output logic [CW-1:0]  count,
    output logic           rsp_out_valid,
    output logic [IDW-1:0] rsp_out_dst,
    output logic [CW-1:0]  rsp_out_tokens
);
    localparam logic [CW-1:0]  FULL   = CW'(TOTAL_TOKENS);
    localparam logic [CW-1:0]  START  = CW'(INIT_TOKENS);
    localparam logic [IDW-1:0] SELFID = IDW'(NODE_ID);

    logic          foreign;
    logic [CW-1:0] give;
    logic [CW-1:0] gain;

    always_comb begin
        foreign = req_in_valid && (req_in_src != SELFID) && (count != '0);
        give    = '0;
        if (foreign) begin
            if (req_in_write)       give = count;
            else if (count == FULL) give = CW'(1);
        end
        gain = rsp_in_valid ? rsp_in_tokens : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count          <= START;
            rsp_out_valid  <= 1'b0;
            rsp_out_dst    <= '0;
            rsp_out_tokens <= '0;
        end else begin
            count          <= count + gain - give;
            rsp_out_valid  <= (give != '0);
            rsp_out_dst    <= req_in_src;
            rsp_out_tokens <= give;
        end
    end
endmodule

// File: rtl/tok_req.sv
`timescale 1ns/1ps
module tok_req
    import tok_pkg::*;
#(
    parameter int unsigned TOTAL_TOKENS = DEF_TOTAL,
    parameter int unsigned TW           = 8,
    parameter int unsigned CW           = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  logic          op_write,
    input  logic [TW-1:0] limit,
    input  logic [CW-1:0] count,
    output logic          pend,
    output logic          req_valid,
    output logic          req_write,
    output logic          done
);
    typedef struct packed {
        logic          busy;
        op_kind_e      kind;
        logic [TW-1:0] tmr;
    } wait_t;

    wait_t          st;
    op_kind_e       op_kind;
    logic           sat_new;
    logic           sat_wait;
    logic [TW:0]    tmr_inc;

    always_comb begin
        op_kind  = op_kind_e'(op_write);
        sat_new  = perm_met(32'(count), TOTAL_TOKENS, op_kind);
        sat_wait = perm_met(32'(count), TOTAL_TOKENS, st.kind);
        tmr_inc  = {1'b0, st.tmr} + {{TW{1'b0}}, 1'b1};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= '{busy: 1'b0, kind: OP_READ, tmr: '0};
            req_valid <= 1'b0;
            req_write <= 1'b0;
            done      <= 1'b0;
        end else begin
            req_valid <= 1'b0;
            done      <= 1'b0;
            if (!st.busy) begin
                if (op_valid) begin
                    if (sat_new) begin
                        done <= 1'b1;
                    end else begin
                        st        <= '{busy: 1'b1, kind: op_kind, tmr: '0};
                        req_valid <= 1'b1;
                        req_write <= op_write;
                    end
                end
            end else if (sat_wait) begin
                st.busy <= 1'b0;
                st.tmr  <= '0;
                done    <= 1'b1;
            end else if (tmr_inc >= {1'b0, limit}) begin
                st.tmr    <= '0;
                req_valid <= 1'b1;
                req_write <= (st.kind == OP_WRITE);
            end else begin
                st.tmr <= tmr_inc[TW-1:0];
            end
        end
    end

    assign pend = st.busy;
endmodule

// File: rtl/tok_line_ctrl.sv
`timescale 1ns/1ps
module tok_line_ctrl
    import tok_pkg::*;
#(
    parameter int unsigned TOTAL_TOKENS = DEF_TOTAL,
    parameter int unsigned INIT_TOKENS  = 0,
    parameter int unsigned NODES        = 4,
    parameter int unsigned NODE_ID      = 0,
    parameter int unsigned TW           = 8,
    localparam int unsigned IDW         = id_width(NODES),
    localparam int unsigned CW          = $clog2(TOTAL_TOKENS + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           op_valid,
    input  logic           op_write,
    input  logic [TW-1:0]  timeout_limit,
    input  logic           req_in_valid,
    input  logic           req_in_write,
    input  logic [IDW-1:0] req_in_src,
    input  logic           rsp_in_valid,
    input  logic [CW-1:0]  rsp_in_tokens,
    output logic           req_out_valid,
    output logic           req_out_write,
    output logic [IDW-1:0] req_out_src,
    output logic           rsp_out_valid,
    output logic [IDW-1:0] rsp_out_dst,
    output logic [CW-1:0]  rsp_out_tokens,
    output logic [CW-1:0]  tokens,
    output logic           rd_ok,
    output logic           wr_ok,
    output logic           pend,
    output logic           done
);
    logic [CW-1:0] count;

    tok_count #(
        .TOTAL_TOKENS(TOTAL_TOKENS), .INIT_TOKENS(INIT_TOKENS),
        .NODE_ID(NODE_ID), .IDW(IDW), .CW(CW)
    ) u_count (
        .clk(clk), .rst(rst),
        .req_in_valid(req_in_valid), .req_in_write(req_in_write),
        .req_in_src(req_in_src),
        .rsp_in_valid(rsp_in_valid), .rsp_in_tokens(rsp_in_tokens),
        .count(count),
        .rsp_out_valid(rsp_out_valid), .rsp_out_dst(rsp_out_dst),
        .rsp_out_tokens(rsp_out_tokens)
    );

    tok_req #(
        .TOTAL_TOKENS(TOTAL_TOKENS), .TW(TW), .CW(CW)
    ) u_req (
        .clk(clk), .rst(rst),
        .op_valid(op_valid), .op_write(op_write),
        .limit(timeout_limit), .count(count),
        .pend(pend), .req_valid(req_out_valid),
        .req_write(req_out_write), .done(done)
    );

    assign tokens      = count;
    assign rd_ok       = perm_met(32'(count), TOTAL_TOKENS, OP_READ);
    assign wr_ok       = perm_met(32'(count), TOTAL_TOKENS, OP_WRITE);
    assign req_out_src = IDW'(NODE_ID);
endmodule

// File: rtl/tok_line_ctrl_chk.sv
`timescale 1ns/1ps
module tok_line_ctrl_chk #(
    parameter int unsigned TOTAL_TOKENS = 16,
    parameter int unsigned NODE_ID      = 0,
    parameter int unsigned IDW          = 2,
    parameter int unsigned CW           = 5
) (
    input logic           clk,
    input logic           rst,
    input logic           req_in_valid,
    input logic           req_in_write,
    input logic [IDW-1:0] req_in_src,
    input logic           rsp_in_valid,
    input logic [CW-1:0]  rsp_in_tokens,
    input logic           req_out_valid,
    input logic           rsp_out_valid,
    input logic [IDW-1:0] rsp_out_dst,
    input logic [CW-1:0]  rsp_out_tokens,
    input logic [CW-1:0]  tokens,
    input logic           pend,
    input logic           done
);
    logic from_peer;
    assign from_peer = req_in_valid && (req_in_src != IDW'(NODE_ID));

    // R11
    token_balance_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |->
        (int'(tokens) == int'($past(tokens))
            + ($past(rsp_in_valid) ? int'($past(rsp_in_tokens)) : 0)
            - (rsp_out_valid ? int'(rsp_out_tokens) : 0)));

    // R4
    write_strip_chk: assert property (@(posedge clk) disable iff (rst)
        (from_peer && req_in_write && tokens != '0) |=>
        (rsp_out_valid && rsp_out_tokens == $past(tokens)
            && rsp_out_dst == $past(req_in_src)));

    // R3
    read_share_chk: assert property (@(posedge clk) disable iff (rst)
        (from_peer && !req_in_write && int'(tokens) == TOTAL_TOKENS) |=>
        (rsp_out_valid && int'(rsp_out_tokens) == 1));

    // R5
    silent_holder_chk: assert property (@(posedge clk) disable iff (rst)
        (!from_peer || tokens == '0) |=> !rsp_out_valid);

    // R7
    issue_on_wait_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> req_out_valid);

    // R10
    done_clears_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !pend);
endmodule

bind tok_line_ctrl tok_line_ctrl_chk #(
    .TOTAL_TOKENS(TOTAL_TOKENS), .NODE_ID(NODE_ID), .IDW(IDW), .CW(CW)
) u_chk (
    .clk(clk), .rst(rst),
    .req_in_valid(req_in_valid), .req_in_write(req_in_write),
    .req_in_src(req_in_src),
    .rsp_in_valid(rsp_in_valid), .rsp_in_tokens(rsp_in_tokens),
    .req_out_valid(req_out_valid),
    .rsp_out_valid(rsp_out_valid), .rsp_out_dst(rsp_out_dst),
    .rsp_out_tokens(rsp_out_tokens),
    .tokens(tokens), .pend(pend), .done(done)
);

// File: tb/test_tok_line_ctrl.sv
`timescale 1ns/1ps
module test_tok_line_ctrl;
    localparam int T   = 16;
    localparam int ID  = 1;
    localparam int TW  = 8;
    localparam int IDW = 2;
    localparam int CW  = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic op_valid = 0, op_write = 0;
    logic [TW-1:0] timeout_limit = 8'd3;
    logic req_in_valid = 0, req_in_write = 0;
    logic [IDW-1:0] req_in_src = '0;
    logic rsp_in_valid = 0;
    logic [CW-1:0] rsp_in_tokens = '0;
    logic req_out_valid, req_out_write, rsp_out_valid;
    logic [IDW-1:0] req_out_src, rsp_out_dst;
    logic [CW-1:0] rsp_out_tokens, tokens;
    logic rd_ok, wr_ok, pend, done;

    always #2.5 clk = ~clk;

    tok_line_ctrl #(.TOTAL_TOKENS(T), .INIT_TOKENS(T), .NODES(4),
                    .NODE_ID(ID), .TW(TW)) i_tok_line_ctrl (.*);

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    // model state
    int m_cnt = T, m_tmr = 0, pool = 0;
    bit m_pend = 0, m_pw = 0;
    bit e_rsp_v, e_req_v, e_req_w, e_done;
    int e_rsp_tok, e_rsp_dst;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit need(input int c, input bit w);
        return w ? (c == T) : (c >= 1);
    endfunction

    // next expected state from requirements R3..R10
    task automatic model(input bit ov, ow, qv, qw, input int qs, input bit sv, input int st, input int lim);
        int give;
        give = 0;
        if (qv && qs != ID && m_cnt != 0) give = qw ? m_cnt : (m_cnt == T ? 1 : 0);
        e_rsp_v = give != 0; e_rsp_tok = give; e_rsp_dst = qs;
        e_req_v = 0; e_done = 0;
        if (!m_pend) begin
            if (ov) begin
                if (need(m_cnt, ow)) e_done = 1;
                else begin m_pend = 1; m_pw = ow; e_req_v = 1; e_req_w = ow; m_tmr = 0; end
            end
        end else if (need(m_cnt, m_pw)) begin
            m_pend = 0; e_done = 1; m_tmr = 0;
        end else if (m_tmr + 1 >= lim) begin
            e_req_v = 1; e_req_w = m_pw; m_tmr = 0;
        end else m_tmr++;
        m_cnt = m_cnt + (sv ? st : 0) - give;
    endtask

    task automatic cyc(input bit ov, ow, qv, qw, input int qs, input bit sv, input int st);
        op_valid = ov; op_write = ow;
        req_in_valid = qv; req_in_write = qw; req_in_src = IDW'(qs);
        rsp_in_valid = sv; rsp_in_tokens = CW'(st);
        if (sv) pool -= st;
        model(ov, ow, qv, qw, qs, sv, st, int'(timeout_limit));
        @(negedge clk);
        chk(int'(tokens) == m_cnt, "R6 count", int'(tokens), m_cnt);
        chk(rd_ok == (m_cnt >= 1), "R2 rd_ok", rd_ok, m_cnt >= 1);
        chk(wr_ok == (m_cnt == T), "R2 wr_ok", wr_ok, m_cnt == T);
        chk(rsp_out_valid == e_rsp_v, "R4 rsp valid", rsp_out_valid, e_rsp_v);
        if (e_rsp_v && rsp_out_valid) begin
            chk(int'(rsp_out_tokens) == e_rsp_tok, "R3 rsp tokens", int'(rsp_out_tokens), e_rsp_tok);
            chk(int'(rsp_out_dst) == e_rsp_dst, "R4 rsp dst", int'(rsp_out_dst), e_rsp_dst);
        end
        chk(req_out_valid == e_req_v, "R9 req pulse", req_out_valid, e_req_v);
        if (e_req_v && req_out_valid) begin
            chk(req_out_write == e_req_w, "R7 req kind", req_out_write, e_req_w);
            chk(int'(req_out_src) == ID, "R7 req src", int'(req_out_src), ID);
        end
        chk(pend == m_pend, "R7 pend", pend, m_pend);
        chk(done == e_done, "R10 done", done, e_done);
        if (rsp_out_valid) pool += int'(rsp_out_tokens);
        chk(int'(tokens) + pool == T, "R11 conservation", int'(tokens) + pool, T);
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0000_5eed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(int'(tokens) == T, "R1 reset count", int'(tokens), T);
        chk(!pend && !req_out_valid && !rsp_out_valid && !done, "R1 reset idle",
            {pend, req_out_valid, rsp_out_valid, done}, 0);
        // R8 write already permitted
        cyc(1, 1, 0, 0, 0, 0, 0);
        chk(done && !req_out_valid && !pend, "R8 immediate done", done, 1);
        // R3 full holder answers read with one token
        cyc(0, 0, 1, 0, 2, 0, 0);
        chk(rsp_out_valid && rsp_out_tokens == 1 && rsp_out_dst == 2, "R3 share one",
            int'(rsp_out_tokens), 1);
        chk(tokens == 15 && rd_ok && !wr_ok, "R2 downgrade", int'(tokens), 15);
        // R3 partial holder ignores read
        cyc(0, 0, 1, 0, 3, 0, 0);
        chk(!rsp_out_valid && tokens == 15, "R3 partial ignores read", int'(tokens), 15);
        // R5 own-id request ignored
        cyc(0, 0, 1, 1, ID, 0, 0);
        chk(!rsp_out_valid && tokens == 15, "R5 own id ignored", int'(tokens), 15);
        // R7 write without permission
        cyc(1, 1, 0, 0, 0, 0, 0);
        chk(pend && req_out_valid && req_out_write, "R7 issue write", req_out_valid, 1);
        // R12 op while pending ignored
        cyc(1, 0, 0, 0, 0, 0, 0);
        chk(!done && !req_out_valid, "R12 op ignored while pending", done, 0);
        idle();
        chk(!req_out_valid, "R9 no early reissue", req_out_valid, 0);
        idle();
        chk(req_out_valid && req_out_write, "R9 reissue after limit 3", req_out_valid, 1);
        // R10 completion after the missing token returns
        cyc(0, 0, 0, 0, 0, 1, 1);
        chk(tokens == 16 && !done, "R10 not yet done", done, 0);
        idle();
        chk(done && !pend && wr_ok, "R10 write completes at full count", done, 1);
        // R4 foreign write strips all
        cyc(0, 0, 1, 1, 3, 0, 0);
        chk(rsp_out_valid && rsp_out_tokens == 16 && rsp_out_dst == 3 && tokens == 0,
            "R4 strip all", int'(rsp_out_tokens), 16);
        // R5 zero holder ignores
        cyc(0, 0, 1, 1, 2, 0, 0);
        chk(!rsp_out_valid, "R5 zero holder write", rsp_out_valid, 0);
        cyc(0, 0, 1, 0, 2, 0, 0);
        chk(!rsp_out_valid, "R5 zero holder read", rsp_out_valid, 0);
        // R4 single token holder answers write
        cyc(0, 0, 0, 0, 0, 1, 1);
        cyc(0, 0, 1, 1, 0, 0, 0);
        chk(rsp_out_valid && rsp_out_tokens == 1 && tokens == 0, "R4 single token", int'(rsp_out_tokens), 1);
        // R9 limit 0 reissues every cycle
        timeout_limit = 8'd0;
        cyc(1, 0, 0, 0, 0, 0, 0);
        chk(req_out_valid && !req_out_write, "R7 issue read", req_out_valid, 1);
        idle();
        chk(req_out_valid, "R9 limit 0 reissue", req_out_valid, 1);
        cyc(0, 0, 0, 0, 0, 1, 2);
        idle();
        chk(done && rd_ok && !pend, "R10 read completes", done, 1);
        // random phase
        for (int ph = 0; ph < 6; ph++) begin
            case (ph)
                0: timeout_limit = 8'd5;
                1: timeout_limit = 8'd1;
                2: timeout_limit = 8'd0;
                3: timeout_limit = 8'd9;
                4: timeout_limit = 8'd2;
                default: timeout_limit = 8'd4;
            endcase
            for (int k = 0; k < 500; k++) begin
                bit ov, ow, qv, qw, sv;
                int qs, st;
                ov = ($urandom % 100) < 12; ow = $urandom % 2;
                qv = ($urandom % 100) < 25; qw = $urandom % 2; qs = $urandom % 4;
                sv = (pool > 0) && (($urandom % 100) < 20);
                st = sv ? 1 + int'($urandom % pool) : 0;
                cyc(ov, ow, qv, qw, qs, sv, st);
            end
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule